// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Thresholds

This block buffers 16-bit audio samples between a simple register bus and a serial audio shifter. One FIFO carries transmit samples. The bus writes them and the serial side takes one per frame slot. A second FIFO carries receive samples the other way. Each direction has its own enable, its own DMA-request enable and its own 6-bit fill threshold. A request line tells an external DMA engine when to refill the transmit FIFO or drain the receive FIFO. No DMA engine is included.

The status word reports the occupancy count of each FIFO together with its empty, almost-empty, full and almost-full flags. Starvation and overflow are recorded as sticky error bits, and so is every completed word transfer on the serial side. All of these sources can be masked one by one. Together with a global enable they drive a single interrupt line and a pending bit. The sticky bits are cleared by writing ones to a dedicated clear register.

Register map (word address on `busAddr`):

| Address | Name | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | TX data | write |
| 2 | RX data | read |
| 3 | interrupt enable | read/write |
| 4 | interrupt status | read |
| 5 | FIFO status | read |
| 6 | clear | write |

Top module: `afifo_top`

## Requirements
- R1: After reset both counts are 0 and both FIFOs read as empty. The control word reads 0x0020_0400, which means TX threshold 4 at bits 13:8, RX threshold 32 at bits 21:16 and every enable bit cleared. `txDmaReq`, `rxDmaReq` and `irq` are low, and `txSample` is 0.
- R2: Words written to address 1 while the TX FIFO is enabled are pushed, using bits 15:0 of the write data. The word at the head is shown on `txSample`. Each `txPop` cycle moves on to the next word, in write order.
- R3: A read of address 2 returns the head RX sample in bits 15:0 and a valid flag of 1 in bit 16, then pops that sample. Samples come out in the order they were pushed. A read of an empty, enabled RX FIFO returns bit 16 = 0 and sets the sticky RX starvation bit (status bit 4).
- R4: A `txPop` on an empty, enabled TX FIFO leaves `txSample` at 0 and sets the sticky TX starvation bit (status bit 10).
- R5: A `rxPush` into a full RX FIFO is dropped and sets the sticky RX overflow bit (status bit 5). A bus write into a full TX FIFO is dropped and sets the sticky TX overflow bit (status bit 11). In both cases the count stays at the depth (32).
- R6: `txDmaReq` is high while the TX FIFO and TX DMA are both enabled (control bits 0 and 2) and the TX count is at or below the TX threshold.
- R7: `rxDmaReq` is high while the RX FIFO and RX DMA are both enabled (control bits 1 and 3) and the RX count is at or above the RX threshold.
- R8: The FIFO status word (address 5) has this layout:
  - RX count in bits 5:0, then empty, almost-empty, full and almost-full in bits 6 to 9.
  - TX count in bits 21:16, then the same four flags in bits 22 to 25.
  - Almost-empty means 1 to 4 entries. Almost-full means 28 to 31 entries.
- R9: The interrupt status word (address 4) has this layout:
  - Bits 11:0 hold the sources. RX uses bits 5:0: empty, almost-empty, full, almost-full, starvation, overflow. TX uses the same order in bits 11:6.
  - Bit 12 is the word-transfer bit and bit 13 is the pending bit.
  - `irq` and the pending bit are high when the global enable (enable-register bit 14) is set and an enabled source is active. Sources are enabled by enable-register bits 11:0, with bit 12 for word transfer.
- R10: Writing ones to address 6 clears the sticky starvation, overflow and word-transfer bits at the same bit positions as in the status word.
- R11: Clearing a FIFO's enable bit flushes that FIFO, so its count reads 0 right away. While disabled, TX writes and RX pushes are ignored.
- R12: The sticky word-transfer bit (status bit 12) is set whenever a word actually leaves the TX FIFO or enters the RX FIFO on the serial side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (pops RX on address 2) |
| busAddr | input | 3 | Register word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from the address |
| txPop | input | 1 | Serial side takes one TX sample |
| txSample | output | 16 | Head TX sample, 0 when empty |
| rxPush | input | 1 | Serial side delivers one RX sample |
| rxSample | input | 16 | RX sample to store |
| txDmaReq | output | 1 | TX refill request |
| rxDmaReq | output | 1 | RX drain request |
| irq | output | 1 | Interrupt, same as the pending bit |

## Verification
The bench builds the block with its default depth of 32 and reset thresholds of 4 (TX) and 32 (RX). With these values the whole RX FIFO can be filled with the default threshold, so the DMA request edge, the full flag and the overflow drop all fall within a single fill sequence. The small TX threshold makes the request drop after the fifth write. The almost-empty and almost-full bands of four entries are reached after a handful of words.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam int SAMPLE_W = 16;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 3;
  localparam int CNT_W    = 6;

  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_TXDATA  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RXDATA  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_IRQEN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_IRQSTAT = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_FSTAT   = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR   = 3'd6;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } fifoStrobe_t;
endpackage

// File: rtl/afifo_ring.sv
module afifo_ring
  import afifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];
endmodule

// File: rtl/afifo_datapath.sv
module afifo_datapath
  import afifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  fifoStrobe_t         strobe,
  input  logic [SAMPLE_W-1:0] txWrData,
  input  logic [SAMPLE_W-1:0] rxWrData,
  output logic [SAMPLE_W-1:0] txHead,
  output logic [SAMPLE_W-1:0] rxHead,
  output logic [CNT_W-1:0]    txCount,
  output logic [CNT_W-1:0]    rxCount
);
  afifo_ring #(.DEPTH(DEPTH), .WIDTH(SAMPLE_W)) u_txRing (
    .clk(clk), .rstN(rstN), .flush(strobe.txFlush), .push(strobe.txPush),
    .pop(strobe.txPop), .wrData(txWrData), .headData(txHead), .count(txCount)
  );

  afifo_ring #(.DEPTH(DEPTH), .WIDTH(SAMPLE_W)) u_rxRing (
    .clk(clk), .rstN(rstN), .flush(strobe.rxFlush), .push(strobe.rxPush),
    .pop(strobe.rxPop), .wrData(rxWrData), .headData(rxHead), .count(rxCount)
  );
endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl
  import afifo_pkg::*;
#(
  parameter int DEPTH         = 32,
  parameter int NEAR          = 4,
  parameter int TX_THRESH_RST = 4,
  parameter int RX_THRESH_RST = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BUS_W-1:0]    busWrData,
  output logic [BUS_W-1:0]    busRdData,
  input  logic                txPop,
  input  logic                rxPush,
  input  logic [SAMPLE_W-1:0] txHead,
  input  logic [SAMPLE_W-1:0] rxHead,
  input  logic [CNT_W-1:0]    txCount,
  input  logic [CNT_W-1:0]    rxCount,
  output fifoStrobe_t         strobe,
  output logic [SAMPLE_W-1:0] txSample,
  output logic                txDmaReq,
  output logic                rxDmaReq,
  output logic                irq
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] AF_C   = CNT_W'(DEPTH - NEAR);
  localparam logic [CNT_W-1:0] NEAR_C = CNT_W'(NEAR);

  logic txEn, rxEn, txDmaEn, rxDmaEn;
  logic [CNT_W-1:0] txThr, rxThr;
  logic [11:0] srcEn;
  logic wordEn, globalEn;
  logic txStarve, txOvf, rxStarve, rxOvf, wordXfer;

  logic wrCtrl, wrIrqEn, wrClear;
  assign wrCtrl  = busWrEn && busAddr == ADDR_CTRL;
  assign wrIrqEn = busWrEn && busAddr == ADDR_IRQEN;
  assign wrClear = busWrEn && busAddr == ADDR_CLEAR;

  logic wrUnused;
  assign wrUnused = ^{busWrData[31:22], busWrData[15:14], busWrData[7:4]};

  logic txEmpty, txAE, txFull, txAF, rxEmpty, rxAE, rxFull, rxAF;
  assign txEmpty = txCount == '0;
  assign txFull  = txCount == FULL_C;
  assign txAE    = !txEmpty && txCount <= NEAR_C;
  assign txAF    = !txFull && txCount >= AF_C;
  assign rxEmpty = rxCount == '0;
  assign rxFull  = rxCount == FULL_C;
  assign rxAE    = !rxEmpty && rxCount <= NEAR_C;
  assign rxAF    = !rxFull && rxCount >= AF_C;

  logic txWrite, rxAccept, rxRead;
  logic txOvfSet, txStarveSet, rxOvfSet, rxStarveSet;
  assign txWrite     = busWrEn && busAddr == ADDR_TXDATA && txEn;
  assign txOvfSet    = txWrite && txFull;
  assign txStarveSet = txPop && txEn && txEmpty;
  assign rxAccept    = rxPush && rxEn;
  assign rxOvfSet    = rxAccept && rxFull;
  assign rxRead      = busRdEn && busAddr == ADDR_RXDATA && rxEn;
  assign rxStarveSet = rxRead && rxEmpty;

  always_comb begin
    strobe.txPush  = txWrite && !txFull;
    strobe.txPop   = txPop && txEn && !txEmpty;
    strobe.txFlush = !txEn || (wrCtrl && !busWrData[0]);
    strobe.rxPush  = rxAccept && !rxFull;
    strobe.rxPop   = rxRead && !rxEmpty;
    strobe.rxFlush = !rxEn || (wrCtrl && !busWrData[1]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEn <= 1'b0; rxEn <= 1'b0; txDmaEn <= 1'b0; rxDmaEn <= 1'b0;
      txThr <= CNT_W'(TX_THRESH_RST);
      rxThr <= CNT_W'(RX_THRESH_RST);
    end else if (wrCtrl) begin
      txEn    <= busWrData[0];
      rxEn    <= busWrData[1];
      txDmaEn <= busWrData[2];
      rxDmaEn <= busWrData[3];
      txThr   <= busWrData[13:8];
      rxThr   <= busWrData[21:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcEn <= '0; wordEn <= 1'b0; globalEn <= 1'b0;
    end else if (wrIrqEn) begin
      srcEn    <= busWrData[11:0];
      wordEn   <= busWrData[12];
      globalEn <= busWrData[14];
    end
  end

  logic [BUS_W-1:0] clr;
  assign clr = wrClear ? busWrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txStarve <= 1'b0; txOvf <= 1'b0; rxStarve <= 1'b0; rxOvf <= 1'b0;
      wordXfer <= 1'b0;
    end else begin
      rxStarve <= (rxStarve && !clr[4])  || rxStarveSet;
      rxOvf    <= (rxOvf    && !clr[5])  || rxOvfSet;
      txStarve <= (txStarve && !clr[10]) || txStarveSet;
      txOvf    <= (txOvf    && !clr[11]) || txOvfSet;
      wordXfer <= (wordXfer && !clr[12]) || strobe.txPop || strobe.rxPush;
    end
  end

  logic [11:0] src;
  logic pending;
  assign src = {txOvf, txStarve, txAF, txFull, txAE, txEmpty,
                rxOvf, rxStarve, rxAF, rxFull, rxAE, rxEmpty};
  assign pending = globalEn && ((|(src & srcEn)) || (wordEn && wordXfer));
  assign irq = pending;

  assign txSample = (txEn && !txEmpty) ? txHead : '0;
  assign txDmaReq = txEn && txDmaEn && txCount <= txThr;
  assign rxDmaReq = rxEn && rxDmaEn && rxCount >= rxThr;

  logic rxValid;
  assign rxValid = rxEn && !rxEmpty;

  always_comb begin
    case (busAddr)
      ADDR_CTRL:    busRdData = {10'b0, rxThr, 2'b0, txThr, 4'b0,
                                 rxDmaEn, txDmaEn, rxEn, txEn};
      ADDR_RXDATA:  busRdData = {15'b0, rxValid, rxValid ? rxHead : 16'h0};
      ADDR_IRQEN:   busRdData = {17'b0, globalEn, 1'b0, wordEn, srcEn};
      ADDR_IRQSTAT: busRdData = {18'b0, pending, wordXfer, src};
      ADDR_FSTAT:   busRdData = {6'b0, txAF, txFull, txAE, txEmpty, txCount,
                                 6'b0, rxAF, rxFull, rxAE, rxEmpty, rxCount};
      default:      busRdData = '0;
    endcase
  end
endmodule

// File: rtl/afifo_top.sv
module afifo_top
  import afifo_pkg::*;
#(
  parameter int DEPTH         = 32,
  parameter int NEAR          = 4,
  parameter int TX_THRESH_RST = 4,
  parameter int RX_THRESH_RST = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        txPop,
  output logic [15:0] txSample,
  input  logic        rxPush,
  input  logic [15:0] rxSample,
  output logic        txDmaReq,
  output logic        rxDmaReq,
  output logic        irq
);
  fifoStrobe_t strobe;
  logic [SAMPLE_W-1:0] txHead, rxHead;
  logic [CNT_W-1:0] txCount, rxCount;

  afifo_ctrl #(
    .DEPTH(DEPTH), .NEAR(NEAR),
    .TX_THRESH_RST(TX_THRESH_RST), .RX_THRESH_RST(RX_THRESH_RST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .txPop(txPop), .rxPush(rxPush), .txHead(txHead), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount), .strobe(strobe),
    .txSample(txSample), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .irq(irq)
  );

  afifo_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txWrData(busWrData[SAMPLE_W-1:0]), .rxWrData(rxSample),
    .txHead(txHead), .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: rtl/afifo_checker.sv
module afifo_checker #(
  parameter int DEPTH = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic        busRdEn,
  input logic        txPop,
  input logic        rxPush,
  input logic [15:0] txSample,
  input logic [5:0]  txCount,
  input logic [5:0]  rxCount
);
  localparam logic [5:0] FULL_C = 6'(DEPTH);

  // R8: occupancy never exceeds the depth
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= FULL_C) && (rxCount <= FULL_C));

  // R4: a pop from an empty TX FIFO sends a zero word
  assert_starve_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && txCount == 6'd0) |-> (txSample == 16'h0000));

  // R5: a push into a full RX FIFO leaves the count at the depth
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == FULL_C && rxPush && !busRdEn && !busWrEn) |=> (rxCount == FULL_C));

  // R2: the TX count moves by at most one per cycle, except a flush to zero
  assert_tx_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txCount != $past(txCount)) |->
      (txCount == $past(txCount) + 6'd1 || txCount + 6'd1 == $past(txCount) ||
       txCount == 6'd0));

  // R3: the RX count moves by at most one per cycle, except a flush to zero
  assert_rx_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount != $past(rxCount)) |->
      (rxCount == $past(rxCount) + 6'd1 || rxCount + 6'd1 == $past(rxCount) ||
       rxCount == 6'd0));
endmodule

bind afifo_top afifo_checker #(.DEPTH(DEPTH)) u_checker (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .txPop(txPop), .rxPush(rxPush), .txSample(txSample),
  .txCount(txCount), .rxCount(rxCount)
);

// File: tb/afifo_top_bench.sv
module afifo_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] busRdData;
  logic        txPop = 1'b0, rxPush = 1'b0;
  logic [15:0] txSample, rxSample = 16'h0;
  logic        txDmaReq, rxDmaReq, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  afifo_top u_afifo_top (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .txPop(txPop), .txSample(txSample), .rxPush(rxPush), .rxSample(rxSample),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .irq(irq)
  );

  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF,
                                         16'hA5A5, 16'h5A5A, 16'h0000, 16'h1234};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic serialPop(output logic [15:0] s);
    @(negedge clk);
    txPop = 1'b1;
    #1 s = txSample;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic serialPush(input logic [15:0] s);
    @(negedge clk);
    rxPush = 1'b1; rxSample = s;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(3'd0, r);  check("R1 control", r, 32'h0020_0400);
    busRead(3'd5, r);  check("R1 fifo status", r, 32'h0040_0040);
    check("R1 txDmaReq", {31'b0, txDmaReq}, 0);
    check("R1 rxDmaReq", {31'b0, rxDmaReq}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 txSample", {16'b0, txSample}, 0);

    busWrite(3'd0, 32'h0020_040F);
    check("R6 req at zero", {31'b0, txDmaReq}, 1);

    // vector table: TX fill with DMA request tracking
    for (int i = 0; i < NVEC; i++) begin
      busWrite(3'd1, {16'hDEAD, VEC[i]});
      check("R6 txDmaReq vs count", {31'b0, txDmaReq}, {31'b0, (i + 1) <= 4});
    end
    busRead(3'd5, r);  check("R8 tx count 8", r, 32'h0008_0040);
    for (int i = 0; i < NVEC; i++) begin
      serialPop(s);
      check("R2 tx order", {16'b0, s}, {16'b0, VEC[i]});
    end

    // R4 starvation, R12 word transfer, R10 clear
    serialPop(s);      check("R4 starve zero", {16'b0, s}, 0);
    busRead(3'd4, r);
    check("R4 starve flag", {31'b0, r[10]}, 1);
    check("R12 word xfer", {31'b0, r[12]}, 1);
    busWrite(3'd6, 32'h0000_1C30);
    busRead(3'd4, r);
    check("R10 cleared", {30'b0, r[12], r[10]}, 0);

    // vector table: RX path
    for (int i = 0; i < NVEC; i++) serialPush(VEC[i]);
    for (int i = 0; i < NVEC; i++) begin
      busRead(3'd2, r);
      check("R3 rx read", r, {15'b0, 1'b1, VEC[i]});
    end
    busRead(3'd2, r);  check("R3 empty read valid", {31'b0, r[16]}, 0);
    busRead(3'd4, r);  check("R3 rx starve flag", {31'b0, r[4]}, 1);

    // R9 interrupt gating
    busWrite(3'd3, 32'h0000_0001);
    check("R9 no global", {31'b0, irq}, 0);
    busWrite(3'd3, 32'h0000_4001);
    check("R9 irq rx empty", {31'b0, irq}, 1);
    busRead(3'd4, r);  check("R9 pending bit", {31'b0, r[13]}, 1);
    serialPush(16'h4444);
    check("R9 irq drops", {31'b0, irq}, 0);
    busRead(3'd2, r);
    busWrite(3'd3, 32'h0);

    // R7 threshold, R5 RX overflow
    for (int i = 0; i < 32; i++) begin
      serialPush(16'h1000 + 16'(i));
      if (i == 30) check("R7 below thr", {31'b0, rxDmaReq}, 0);
    end
    check("R7 at thr", {31'b0, rxDmaReq}, 1);
    busRead(3'd5, r);  check("R8 rx full", r, 32'h0040_0120);
    serialPush(16'hBEEF);
    busRead(3'd5, r);  check("R5 rx count held", r, 32'h0040_0120);
    busRead(3'd4, r);  check("R5 rx ovf flag", {31'b0, r[5]}, 1);
    busRead(3'd2, r);  check("R5 rx first kept", r, 32'h0001_1000);
    busRead(3'd5, r);  check("R8 rx almost full", r, 32'h0040_021F);
    check("R7 after read", {31'b0, rxDmaReq}, 0);
    for (int i = 1; i < 32; i++) begin
      busRead(3'd2, r);
      if (i == 31) check("R5 last kept", r, 32'h0001_101F);
    end

    // R11 flush and disabled write
    for (int i = 0; i < 3; i++) busWrite(3'd1, 32'h0000_0100 + i);
    busRead(3'd5, r);  check("R8 tx almost empty", r, 32'h0083_0040);
    busWrite(3'd0, 32'h0020_040E);
    busRead(3'd5, r);  check("R11 flushed", r, 32'h0040_0040);
    busWrite(3'd1, 32'h0000_7777);
    busRead(3'd5, r);  check("R11 write ignored", r, 32'h0040_0040);
    check("R11 no dma", {31'b0, txDmaReq}, 0);

    // R5 TX overflow
    busWrite(3'd0, 32'h0020_040F);
    for (int i = 0; i < 33; i++) busWrite(3'd1, 32'h0000_2000 + i);
    busRead(3'd5, r);  check("R5 tx full", r, 32'h0120_0040);
    busRead(3'd4, r);  check("R5 tx ovf flag", {31'b0, r[11]}, 1);
    serialPop(s);      check("R5 tx first kept", {16'b0, s}, 32'h0000_2000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule